// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt lines from a processor's surroundings and turns them into two active-low requests for the core: a normal request (`irq_n`) and a fast request (`fiq_n`). Source 0 is the fast line and only ever drives `fiq_n`. Sources 1 to 3 are the external request lines, and the remaining sources belong to on-chip peripherals. Each source has its own mask bit, a priority from 0 to 7, and a choice of level or rising-edge sensing.

Software works through a small word-addressed register port. Reading the vector register returns the number of the winning source and acknowledges it. The acknowledge pushes that source's priority onto a level stack and clears the source's edge latch. Writing the end-of-interrupt register pops the stack. While a handler runs, only a source of strictly higher priority can raise `irq_n` again, so handlers nest by priority. If nothing qualifies when the vector is read, a programmable spurious value is returned.

A protect mode is provided for debuggers. In this mode a vector read only looks at the controller, and the acknowledge is done by writing the vector register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_n` and `fiq_n` are 1, the mask (address 0x12) reads 0, the pending register (0x13) reads 0, the spurious register (0x16) reads 0xFF, and the level stack is empty.
- R2: Writing the enable register (0x10) sets each mask bit whose data bit is 1. Writing the disable register (0x11) clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and the result reads back at 0x12.
- R3: `fiq_n` is 0 exactly when source 0 is pending and unmasked. Source 0 never lowers `irq_n` and is never returned as a vector.
- R4: `irq_n` is 0 exactly when some unmasked pending source among 1..N-1 has a priority greater than the stack top. An empty stack lets any priority through.
- R5: A vector read (0x14) returns the qualifying source with the highest priority (config address n, bits [2:0]). Among equal priorities the lowest source number wins.
- R6: If no source qualifies, a vector read returns the spurious register value and leaves the stack unchanged.
- R7: In normal mode a qualifying vector read pushes the winner's priority. A write to 0x15 pops the stack and restores the previous level.
- R8: A source configured for edge sensing (config bit 3 = 1) latches pending on a rising input edge and holds it after the input falls, until that source is acknowledged. A level source's pending bit follows the input one cycle later.
- R9: With protect mode on (0x17 bit 0 = 1), a vector read returns the same value but changes no state. A write to 0x14 then performs the acknowledge.
- R10: Writing 1s to the pending-clear register (0x18) clears the matching edge latches.
- R11: The stack holds up to 8 levels. An end-of-interrupt write on an empty stack is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NSRC | Active-high source lines, synchronous to clk; bit 0 is the fast line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
The assertions assume that `src_in` is already synchronous to `clk`. They also assume that a cycle carries at most one register access, so a read and a write never coincide, and that NSRC does not exceed the data width. The bench changes inputs one time unit after a rising edge and never raises `reg_rd` and `reg_wr` together. Nested acknowledges use strictly rising priorities, which keeps the stack within its eight entries.

// File: rtl/prio_irq_pkg.sv
// Package: shared widths, the register address map and the priority type
// used throughout the interrupt controller.
package prio_irq_pkg;
    localparam int NLEVELS = 8;
    localparam int PRIO_W  = $clog2(NLEVELS);
    localparam int ADDR_W  = 5;

    typedef logic [PRIO_W-1:0] prio_t;

    // Addresses 0 .. NSRC-1 hold the per-source configuration words.
    localparam logic [ADDR_W-1:0] A_ENABLE  = 5'h10;
    localparam logic [ADDR_W-1:0] A_DISABLE = 5'h11;
    localparam logic [ADDR_W-1:0] A_MASK    = 5'h12;
    localparam logic [ADDR_W-1:0] A_PEND    = 5'h13;
    localparam logic [ADDR_W-1:0] A_VECTOR  = 5'h14;
    localparam logic [ADDR_W-1:0] A_EOI     = 5'h15;
    localparam logic [ADDR_W-1:0] A_SPUR    = 5'h16;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'h17;
    localparam logic [ADDR_W-1:0] A_PCLR    = 5'h18;
endpackage

// File: rtl/pic_src_bank.sv
// Module: per-source capture and mask state.
// For each source it holds the mask bit and the pending bit. Pending either
// follows the input (level) or latches a rising edge until cleared (edge).
// Assumes src_in is synchronous to clk.
module pic_src_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] set_mask,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] ack_clr,
    input  logic [NSRC-1:0] sw_clr,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] mask
);
    logic [NSRC-1:0] prev_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Track the previous input, the mask and the pending state of source i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i]  <= 1'b0;
                mask[i]    <= 1'b0;
                pending[i] <= 1'b0;
            end else begin
                prev_q[i] <= src_in[i];
                if (set_mask[i])      mask[i] <= 1'b1;
                else if (clr_mask[i]) mask[i] <= 1'b0;
                if (!edge_mode[i])                pending[i] <= src_in[i];
                else if (src_in[i] && !prev_q[i]) pending[i] <= 1'b1;
                else if (ack_clr[i] || sw_clr[i]) pending[i] <= 1'b0;
            end
        end

        a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            edge_mode[i] && pending[i] && !ack_clr[i] && !sw_clr[i] |=> pending[i]);
        a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[i] |=> mask[i]);
        a_r2_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[i] && !set_mask[i] |=> !mask[i]);
    end
endmodule

// File: rtl/pic_arbiter.sv
// Module: combinational winner selection.
// Picks the candidate with the highest priority. Ties go to the lowest index
// because a later index must strictly exceed the current best to take over.
module pic_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0]         cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                    found,
    output logic [$clog2(NSRC)-1:0] win_idx,
    output prio_t                   win_prio
);
    localparam int IW = $clog2(NSRC);

    // Scan the sources upward and keep the strictly better one.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!found || prio[i] > win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_level_stack.sv
// Module: stack of the priority levels being serviced.
// A push stores the acknowledged level and a pop restores the one below it.
// Assumes DEPTH is a power of two. A pop on an empty stack is ignored.
module pic_level_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = NLEVELS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  prio_t                      lvl,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output prio_t                      top,
    output logic                       nonempty
);
    localparam int IW = $clog2(DEPTH);
    localparam int DW = $clog2(DEPTH + 1);

    prio_t ent_q [DEPTH];

    // Update the entries and the fill count on a push or a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
        end else if (push && !pop && depth < DW'(DEPTH)) begin
            ent_q[depth[IW-1:0]] <= lvl;
            depth <= depth + 1'b1;
        end else if (pop && !push && depth != '0) begin
            depth <= depth - 1'b1;
        end else if (push && pop && depth != '0) begin
            ent_q[IW'(depth - 1'b1)] <= lvl;
        end
    end

    assign nonempty = (depth != '0);
    assign top      = ent_q[IW'(depth - 1'b1)];

    a_r11_push_room: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> depth < DW'(DEPTH));
    a_r11_pop_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && depth == '0 |=> depth == '0);
    a_r7_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> top == $past(lvl));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the vectored priority interrupt controller.
// Holds the configuration registers and decodes register accesses, then
// combines the source bank, the arbiter and the level stack into irq_n, fiq_n
// and the vector. Assumes one register access per cycle and NSRC <= DATA_W.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                NSRC     = 8,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] SPUR_RST = {DATA_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n,
    output logic              fiq_n
);
    localparam int SW = $clog2(NSRC);
    localparam int DW = $clog2(NLEVELS + 1);
    localparam logic [ADDR_W-1:0] CFG_LIM = ADDR_W'(NSRC);

    logic [NSRC-1:0][PRIO_W-1:0] cfg_prio_q;
    logic [NSRC-1:0]             cfg_edge_q;
    logic [DATA_W-1:0]           spur_q;
    logic                        protect_q;

    logic [NSRC-1:0] pending, mask, cand, set_mask, clr_mask, ack_clr, sw_clr;
    logic            found, eligible, ack, push, pop, nonempty;
    logic            vec_rd, vec_wr;
    logic [SW-1:0]   win_idx;
    prio_t           win_prio, top;
    logic [DW-1:0]   depth;

    // Write the per-source configuration, the spurious value and protect mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_prio_q <= '0;
            cfg_edge_q <= '0;
            spur_q     <= SPUR_RST;
            protect_q  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr < CFG_LIM) begin
                cfg_prio_q[reg_addr[SW-1:0]] <= reg_wdata[PRIO_W-1:0];
                cfg_edge_q[reg_addr[SW-1:0]] <= reg_wdata[PRIO_W];
            end
            if (reg_addr == A_SPUR) spur_q    <= reg_wdata;
            if (reg_addr == A_CTRL) protect_q <= reg_wdata[0];
        end
    end

    // Decode the command registers into per-source strobes.
    always_comb begin
        set_mask = (reg_wr && reg_addr == A_ENABLE)  ? reg_wdata[NSRC-1:0] : '0;
        clr_mask = (reg_wr && reg_addr == A_DISABLE) ? reg_wdata[NSRC-1:0] : '0;
        sw_clr   = (reg_wr && reg_addr == A_PCLR)    ? reg_wdata[NSRC-1:0] : '0;
        vec_rd   = reg_rd && reg_addr == A_VECTOR;
        vec_wr   = reg_wr && reg_addr == A_VECTOR;
        pop      = reg_wr && reg_addr == A_EOI;
        ack      = eligible && (protect_q ? vec_wr : vec_rd);
        push     = ack;
        ack_clr  = ack ? (NSRC'(1) << win_idx) : '0;
    end

    pic_src_bank #(.NSRC(NSRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(cfg_edge_q),
        .set_mask(set_mask), .clr_mask(clr_mask), .ack_clr(ack_clr),
        .sw_clr(sw_clr), .pending(pending), .mask(mask)
    );

    // Only the normal sources take part in vectoring; source 0 is excluded.
    assign cand = pending & mask & ~NSRC'(1);

    pic_arbiter #(.NSRC(NSRC)) u_arb (
        .cand(cand), .prio(cfg_prio_q), .found(found),
        .win_idx(win_idx), .win_prio(win_prio)
    );

    pic_level_stack #(.DEPTH(NLEVELS)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .lvl(win_prio),
        .depth(depth), .top(top), .nonempty(nonempty)
    );

    // A winner qualifies only when it is above the level being serviced.
    assign eligible = found && (!nonempty || win_prio > top);
    assign irq_n    = !eligible;
    assign fiq_n    = !(pending[0] && mask[0]);

    // Return the register selected by the address.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < CFG_LIM)
            reg_rdata = DATA_W'({cfg_edge_q[reg_addr[SW-1:0]], cfg_prio_q[reg_addr[SW-1:0]]});
        else begin
            case (reg_addr)
                A_MASK:   reg_rdata = DATA_W'(mask);
                A_PEND:   reg_rdata = DATA_W'(pending);
                A_VECTOR: reg_rdata = eligible ? DATA_W'(win_idx) : spur_q;
                A_SPUR:   reg_rdata = spur_q;
                A_CTRL:   reg_rdata = DATA_W'(protect_q);
                default:  reg_rdata = '0;
            endcase
        end
    end

    a_r3_fast_not_vectored: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> win_idx != '0);
    a_r4_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (pending[NSRC-1:1] & mask[NSRC-1:1]) != '0);
    a_r6_spurious_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd && !eligible && !reg_wr |=> $stable(depth));
    a_r9_protect_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd && protect_q && !reg_wr |=> $stable(depth));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_EN = 5'h10, A_DIS = 5'h11, A_MSK = 5'h12,
        A_PND = 5'h13, A_VEC = 5'h14, A_EOI = 5'h15, A_SPR = 5'h16,
        A_CTL = 5'h17, A_PCL = 5'h18;

    // {source inputs[7:0], priorities 3 bits per source [23:0], expected vector[7:0]}
    localparam logic [39:0] VEC_TAB [8] = '{
        {8'h00, 24'h000000, 8'hFF},   // nothing pending: spurious
        {8'h04, 24'h000000, 8'h02},   // single source
        {8'h0A, 24'h000A10, 8'h03},   // higher priority wins
        {8'h0A, 24'h000A28, 8'h01},   // tie: lower index wins
        {8'h01, 24'h000000, 8'hFF},   // fast only: not vectored
        {8'hF0, 24'h7F9000, 8'h05},   // peripherals, tie at 7
        {8'h80, 24'h000000, 8'h07},   // highest index alone
        {8'hFE, 24'hDB6DB6, 8'h01}    // all equal
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_in = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n, fiq_n;
    int         checks = 0, errors = 0;
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic cfg(int s, logic edg, logic [2:0] p);
        wr(5'(s), {4'b0, edg, p});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq_n", 8'(irq_n), 8'h1);
        chk("R1 fiq_n", 8'(fiq_n), 8'h1);
        rst_n = 1'b1;
        rd(A_MSK, d); chk("R1 mask", d, 8'h00);
        rd(A_PND, d); chk("R1 pending", d, 8'h00);
        rd(A_SPR, d); chk("R1 spurious", d, 8'hFF);

        // R2: set/clear semantics, zeros ignored
        wr(A_EN, 8'h0F);  wr(A_EN, 8'h00);
        rd(A_MSK, d); chk("R2 enable", d, 8'h0F);
        wr(A_DIS, 8'h05); wr(A_DIS, 8'h00);
        rd(A_MSK, d); chk("R2 disable", d, 8'h0A);
        wr(A_EN, 8'hFF);

        // Table walk: R3 R4 R5 R6
        for (int e = 0; e < 8; e++) begin
            for (int s = 0; s < 8; s++) cfg(s, 1'b0, VEC_TAB[e][8 + 3*s +: 3]);
            src_in = VEC_TAB[e][39:32];
            tick();
            chk($sformatf("R4 irq_n entry %0d", e), 8'(irq_n),
                (VEC_TAB[e][7:0] == 8'hFF) ? 8'h1 : 8'h0);
            chk($sformatf("R3 fiq_n entry %0d", e), 8'(fiq_n),
                8'(!VEC_TAB[e][32]));
            rd(A_VEC, d);
            chk($sformatf("R5 vector entry %0d", e), d, VEC_TAB[e][7:0]);
            src_in = '0;
            wr(A_EOI, 8'h00);
            tick();
        end
        for (int s = 0; s < 8; s++) cfg(s, 1'b0, 3'd0);

        // R7: nesting by priority
        cfg(1, 1'b0, 3'd3); cfg(2, 1'b0, 3'd5);
        src_in = 8'h02; tick();
        chk("R7 irq raised", 8'(irq_n), 8'h0);
        rd(A_VEC, d); chk("R7 first vector", d, 8'h01);
        chk("R7 same level masked", 8'(irq_n), 8'h1);
        src_in = 8'h06; tick();
        chk("R7 higher preempts", 8'(irq_n), 8'h0);
        rd(A_VEC, d); chk("R7 nested vector", d, 8'h02);
        chk("R7 nested irq_n", 8'(irq_n), 8'h1);
        src_in = 8'h02;
        wr(A_EOI, 8'h00);
        chk("R7 level restored", 8'(irq_n), 8'h1);
        wr(A_EOI, 8'h00);
        chk("R7 stack empty", 8'(irq_n), 8'h0);
        rd(A_VEC, d); wr(A_EOI, 8'h00);
        src_in = '0; tick();

        // R6: spurious read does not push
        src_in = 8'h02; tick();
        rd(A_VEC, d); chk("R6 ack", d, 8'h01);
        rd(A_VEC, d); chk("R6 spurious", d, 8'hFF);
        wr(A_SPR, 8'h5A);
        rd(A_VEC, d); chk("R6 programmed spurious", d, 8'h5A);
        wr(A_EOI, 8'h00);
        chk("R6 no push", 8'(irq_n), 8'h0);
        src_in = '0; tick();

        // R8: level follows input, edge latches
        cfg(3, 1'b0, 3'd1);
        src_in = 8'h08; tick();
        rd(A_PND, d); chk("R8 level set", d, 8'h08);
        src_in = '0; tick();
        rd(A_PND, d); chk("R8 level follows", d, 8'h00);
        cfg(4, 1'b1, 3'd2);
        src_in = 8'h10; tick(); src_in = '0; tick();
        rd(A_PND, d); chk("R8 edge held", d, 8'h10);
        chk("R8 edge irq", 8'(irq_n), 8'h0);
        rd(A_VEC, d); chk("R8 edge vector", d, 8'h04);
        rd(A_PND, d); chk("R8 edge cleared by ack", d, 8'h00);
        wr(A_EOI, 8'h00);
        chk("R8 idle", 8'(irq_n), 8'h1);

        // R9: protect mode
        wr(A_CTL, 8'h01);
        src_in = 8'h10; tick(); src_in = '0; tick();
        rd(A_VEC, d); chk("R9 read one", d, 8'h04);
        rd(A_VEC, d); chk("R9 read two", d, 8'h04);
        chk("R9 no push", 8'(irq_n), 8'h0);
        rd(A_PND, d); chk("R9 pending kept", d, 8'h10);
        wr(A_VEC, 8'h00);
        chk("R9 write acks", 8'(irq_n), 8'h1);
        rd(A_PND, d); chk("R9 pending cleared", d, 8'h00);
        wr(A_EOI, 8'h00);
        wr(A_CTL, 8'h00);

        // R10: software clear of edge latch
        src_in = 8'h10; tick(); src_in = '0; tick();
        wr(A_PCL, 8'h10);
        rd(A_PND, d); chk("R10 cleared", d, 8'h00);
        chk("R10 irq_n", 8'(irq_n), 8'h1);

        // R11: empty pops ignored, deep stack
        wr(A_EOI, 8'h00); wr(A_EOI, 8'h00);
        cfg(2, 1'b0, 3'd0);
        src_in = 8'h04; tick();
        chk("R11 empty pop ignored", 8'(irq_n), 8'h0);
        src_in = '0; tick();
        for (int s = 1; s < 8; s++) cfg(s, 1'b0, 3'(s));
        for (int s = 1; s < 8; s++) begin
            src_in[s] = 1'b1; tick();
            rd(A_VEC, d);
            chk($sformatf("R11 depth %0d vector", s), d, 8'(s));
        end
        chk("R11 full nest irq_n", 8'(irq_n), 8'h1);
        wr(A_EOI, 8'h00);
        chk("R11 pop reveals", 8'(irq_n), 8'h0);
        rd(A_VEC, d); chk("R11 re-vector", d, 8'h07);
        for (int k = 0; k < 9; k++) wr(A_EOI, 8'h00);
        src_in = '0; tick();
        chk("R11 drained", 8'(irq_n), 8'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule